// File: doc/BRIEF.md
# Prioritized clear-on-read interrupt vector

This block holds the interrupt flags of a serial peripheral and turns them into two interrupt lines plus two read-only vector registers, one per line. Each source has an enable and a line-select bit. A vector register reports the offset of the most urgent source that is latched, enabled and routed to its line. Offset 0 means nothing is pending. Flag bit n reports as offset n+1, and a lower offset wins.

An interrupt handler reads the vector register of the line that fired. The read returns the current offset and clears that flag. In the next cycle the register moves on to the next pending source. The transmit flag (bit 8) and the receive flag (bit 9) are exempt from this clear-on-read. They drop only through their dedicated clear inputs, so while one of them is the top-priority pending source, repeated reads keep returning its offset.

Top module: `irq_vector_unit`

## Requirements
- R1: After synchronous reset, all flags are clear, both lines are low and both vector registers read 0.
- R2: A vector register reports 0 when nothing is pending on its line. Otherwise it reports n+1, where n is the lowest-numbered flag bit that is set, enabled and routed to that line.
- R3: A source whose line-select bit is 0 is reported in the register at address 0x20. A source whose line-select bit is 1 is reported in the register at address 0x24.
- R4: A read of a vector register returns the offset in bits 3:0 and zeros in bits 31:4. A read of any other address returns 0.
- R5: A read returns the offset as it stood before the clear. The flag behind a nonzero returned offset is clear from the next cycle on, and the register then shows the next pending source.
- R6: Flag bits 8 and 9 are never cleared by a vector read. They are cleared only by their bit of the clear input.
- R7: A set pulse on a flag takes priority over a clearing read or a clear-input pulse on the same flag in the same cycle, so the flag stays set.
- R8: A write strobe to any address changes no flag and no output.
- R9: Each interrupt line is high exactly while its vector register is nonzero.
- R10: A latched flag whose enable is low is not reported and cannot be cleared by a read. It becomes visible once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_set_i | input | 14 | Per-source set pulses |
| flag_clr_i | input | 14 | Per-source dedicated clear pulses |
| src_en_i | input | 14 | Per-source enable |
| src_line_i | input | 14 | Per-source line select (0: line 0, 1: line 1) |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe (ignored) |
| bus_rdata_o | output | 32 | Read data |
| irq_line0_o | output | 1 | Interrupt line 0 |
| irq_line1_o | output | 1 | Interrupt line 1 |

## Verification
The assertions check several rules on every cycle. A set pulse always leaves its flag set. The exempt bits survive reads. A read clears at most one flag. Each line agrees with its vector, the upper read bits stay zero, and the read-clear takes effect one cycle after a read. The priority order itself, the routing of each source to the right register, the advance to the next source after a read, and the visibility of a flag after it is enabled late are shown only by the bench's scenarios. In those scenarios a behavioural model is compared with the ports on every cycle.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

    localparam int VEC_W   = 4;
    localparam int MAX_SRC = (1 << VEC_W) - 1;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] LINE0_ADDR = 8'h20;
    localparam logic [ADDR_W-1:0] LINE1_ADDR = 8'h24;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_LINE0 = 2'd1,
        RSEL_LINE1 = 2'd2
    } rsel_e;

    typedef struct packed {
        logic active;
        logic line;
    } rd_req_t;

    // Lowest set bit wins; bit n reports as n+1; no bit set reports 0.
    function automatic vec_t first_pending(input logic [MAX_SRC-1:0] pend);
        vec_t r;
        r = '0;
        for (int i = MAX_SRC - 1; i >= 0; i--) begin
            if (pend[i]) r = vec_t'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_vector_pkg::*;
#(
    parameter int               NUM_SRC    = 14,
    parameter logic [NUM_SRC-1:0] NOCLR_MASK = 14'h0300
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] rdclr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    logic [NUM_SRC-1:0] kill;
    logic [NUM_SRC-1:0] flags_d;

    always_comb begin
        kill    = clr_i | (rdclr_i & ~NOCLR_MASK);
        flags_d = (flags_o & ~kill) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= flags_d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R7: a set pulse always leaves the flag set
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flags_o[i]);

        if (NOCLR_MASK[i]) begin : g_exempt
            // R6: exempt flags survive anything but their own clear
            a_r6_exempt_kept: assert property (@(posedge clk) disable iff (rst)
                (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
        end else begin : g_normal
            // R5: a read-clear without a set empties the flag next cycle
            a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
                (rdclr_i[i] && !set_i[i]) |=> !flags_o[i]);
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_vector_pkg::*;
#(
    parameter int NUM_SRC = 14
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output vec_t               vec_o,
    output logic               any_o
);

    logic [MAX_SRC-1:0] padded;

    always_comb begin
        padded = MAX_SRC'(pend_i);
        vec_o  = first_pending(padded);
        any_o  = |pend_i;
    end

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_vector_pkg::*;
#(
    parameter int                 NUM_SRC    = 14,
    parameter logic [NUM_SRC-1:0] NOCLR_MASK = 14'h0300
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] flag_set_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [NUM_SRC-1:0] src_line_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_rd_i,
    input  logic               bus_wr_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_line0_o,
    output logic               irq_line1_o
);

    localparam int NUM_LINES = 2;

    initial begin
        a_cfg_src_fits: assert (NUM_SRC <= MAX_SRC && NUM_SRC > 0);
    end

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] rdclr;
    logic [NUM_SRC-1:0] pend   [NUM_LINES];
    vec_t               vec    [NUM_LINES];
    logic               any    [NUM_LINES];
    rsel_e              rsel;
    rd_req_t            req;
    vec_t               sel_vec;

    irq_flag_bank #(
        .NUM_SRC    (NUM_SRC),
        .NOCLR_MASK (NOCLR_MASK)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (flag_set_i),
        .clr_i   (flag_clr_i),
        .rdclr_i (rdclr),
        .flags_o (flags)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_comb begin
            pend[l] = flags & src_en_i & (l == 0 ? ~src_line_i : src_line_i);
        end
        irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
            .pend_i (pend[l]),
            .vec_o  (vec[l]),
            .any_o  (any[l])
        );
    end

    // Read decode
    always_comb begin
        rsel = RSEL_NONE;
        if (bus_rd_i) begin
            if (bus_addr_i == LINE0_ADDR)      rsel = RSEL_LINE0;
            else if (bus_addr_i == LINE1_ADDR) rsel = RSEL_LINE1;
        end
        req.active = (rsel != RSEL_NONE);
        req.line   = (rsel == RSEL_LINE1);
        sel_vec    = req.active ? vec[req.line] : '0;
        bus_rdata_o = {{(DATA_W-VEC_W){1'b0}}, sel_vec};
    end

    // One-hot clear request for the flag behind the offset being returned
    always_comb begin
        rdclr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            rdclr[i] = req.active && (sel_vec == vec_t'(i + 1));
        end
    end

    assign irq_line0_o = any[0];
    assign irq_line1_o = any[1];

    // R5: a read clears at most one flag
    a_r5_single_clear: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rdclr));

    // R4: upper read bits are always zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_o[DATA_W-1:VEC_W] == '0);

    // R9: each line agrees with its vector
    a_r9_line0_vec: assert property (@(posedge clk) disable iff (rst)
        irq_line0_o == (vec[0] != '0));
    a_r9_line1_vec: assert property (@(posedge clk) disable iff (rst)
        irq_line1_o == (vec[1] != '0));

    // R8: a bare write with no set or clear activity changes no flag
    a_r8_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && !bus_rd_i && flag_set_i == '0 && flag_clr_i == '0)
        |=> $stable(flags));

endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

    localparam int N = 14;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   flag_set, flag_clr, src_en, src_line;
    logic [7:0]     addr;
    logic           rd, wr;
    logic [31:0]    rdata;
    logic           irq0, irq1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit mf [N];

    always #2 clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst(rst), .flag_set_i(flag_set), .flag_clr_i(flag_clr),
        .src_en_i(src_en), .src_line_i(src_line), .bus_addr_i(addr),
        .bus_rd_i(rd), .bus_wr_i(wr), .bus_rdata_o(rdata),
        .irq_line0_o(irq0), .irq_line1_o(irq1)
    );

    function automatic int mvec(int line);
        for (int i = 0; i < N; i++)
            if (mf[i] && src_en[i] && (int'(src_line[i]) == line)) return i + 1;
        return 0;
    endfunction

    function automatic int exp_rdata();
        if (!rd) return 0;
        if (addr == 8'h20) return mvec(0);
        if (addr == 8'h24) return mvec(1);
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        int v0, v1;
        bit nf;
        bit hit;
        v0 = mvec(0);
        v1 = mvec(1);
        for (int i = 0; i < N; i++) begin
            nf  = mf[i];
            hit = rd && ((addr == 8'h20 && v0 == i + 1) || (addr == 8'h24 && v1 == i + 1));
            if (rst) nf = 0;
            else if (flag_set[i]) nf = 1;
            else if (flag_clr[i]) nf = 0;
            else if (hit && i != 8 && i != 9) nf = 0;
            mf[i] = nf;
        end
    endtask

    // Inputs are set at a negedge before calling step
    task automatic step(string tag);
        #1;
        if (!rst) begin
            check(tag, "rdata", int'(rdata), exp_rdata());
            check("R9 R3", "irq0", int'(irq0), mvec(0) != 0);
            check("R9 R3", "irq1", int'(irq1), mvec(1) != 0);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        flag_set = '0;
        flag_clr = '0;
        rd = 1'b0;
        wr = 1'b0;
    endtask

    task automatic rd_at(logic [7:0] a, string tag);
        rd = 1'b1;
        addr = a;
        step(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mf[i] = 0;
        rst = 1'b1; flag_set = '0; flag_clr = '0; src_en = '0; src_line = '0;
        addr = '0; rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        step("R1");
        step("R1");
        rst = 1'b0;
        // R1: reset state
        rd_at(8'h20, "R1");
        rd_at(8'h24, "R1");

        // R2 R3 R5: priority, routing and advance
        src_en = '1;
        src_line = 14'b11_1111_1000_0000;   // bits 0..6 -> line 0
        flag_set = 14'h0024 | 14'h0400;     // bits 2,5 (line 0), 10 (line 1)
        step("R2");
        rd_at(8'h20, "R2 R5");               // returns 3
        rd_at(8'h20, "R5");                  // returns 6
        rd_at(8'h20, "R5");                  // returns 0
        rd_at(8'h24, "R3");                  // returns 11
        step("R3");

        // R4: other addresses and upper bits
        flag_set = 14'h0002;
        step("R4");
        rd_at(8'h33, "R4");
        rd_at(8'h21, "R4");
        rd_at(8'h20, "R4");

        // R6: exempt flags stay until their own clear
        flag_set = 14'h0300 | 14'h1000;
        step("R6");
        rd_at(8'h24, "R6");                  // 9
        rd_at(8'h24, "R6");                  // still 9
        flag_clr = 14'h0100;
        step("R6");
        rd_at(8'h24, "R6");                  // 10
        rd_at(8'h24, "R6");                  // still 10
        flag_clr = 14'h0200;
        step("R6");
        rd_at(8'h24, "R6");                  // 13
        rd_at(8'h24, "R6");                  // 0

        // R7: set beats read-clear and dedicated clear
        flag_set = 14'h0001;
        step("R7");
        flag_set = 14'h0001;
        rd_at(8'h20, "R7");
        rd_at(8'h20, "R7");                  // still 1
        flag_set = 14'h0001; flag_clr = 14'h0001;
        step("R7");
        rd_at(8'h20, "R7");                  // 1 again
        step("R7");

        // R10: disabled source invisible and not cleared
        src_en = ~14'h0008;
        flag_set = 14'h0008;
        step("R10");
        rd_at(8'h20, "R10");                 // 0
        src_en = '1;
        step("R10");
        rd_at(8'h20, "R10");                 // 4
        step("R10");

        // R8: writes ignored
        flag_set = 14'h0010 | 14'h0800;
        step("R8");
        wr = 1'b1; addr = 8'h20; step("R8");
        wr = 1'b1; addr = 8'h24; step("R8");
        rd_at(8'h20, "R8");                  // 5
        rd_at(8'h24, "R8");                  // 12

        // Mixed random traffic
        for (int k = 0; k < 600; k++) begin
            flag_set = N'($urandom) & N'($urandom) & N'($urandom);
            flag_clr = N'($urandom) & N'($urandom) & N'($urandom);
            if (k % 50 == 0) begin
                src_en   = N'($urandom);
                src_line = N'($urandom);
            end
            rd   = ($urandom % 2) == 1;
            wr   = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: addr = 8'h20;
                1: addr = 8'h24;
                default: addr = 8'($urandom);
            endcase
            step("R2 R5 R6 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule